// File: doc/BRIEF.md
# Distributed CAS-before-RAS Refresh Scheduler

This block keeps a DRAM's contents alive by issuing one CAS-before-RAS refresh per refresh slot, spread evenly over the retention window. The device picks the row from its own internal counter, so the block drives no address. It only produces the RAS, CAS and WE strobes, with WE held high throughout. A free-running interval timer marks each slot. Every slot adds one to a count of owed refreshes, and while anything is owed the block asks the memory access controller for the bus.

Once the grant is present, the sequencer takes the bus and runs three timed phases. First CAS falls. Then RAS falls while CAS stays low. Then both strobes return high for a precharge that covers both the RAS precharge time and the full cycle time. After that the bus is released. If the grant stays high while refreshes are still owed, refreshes follow back to back. The owed count saturates. It raises an urgent flag once it reaches a threshold, so the controller can give refresh priority over data traffic and the retention budget is still met.

Top module: `cbr_refresh_sched`

## Requirements
- R1: The refresh slot timer runs without stopping from reset release and expires once every `floor(slot_ns / CLK_PERIOD_NS)` clock cycles. slot_ns is 15625 for RATE_SEL=0 (4,096 refreshes per 64 ms), 7812 for RATE_SEL=1 (8,192 per 64 ms) and 31250 for RATE_SEL=2 (4,096 per 128 ms). The first expiry raises `bus_req_o` at the clock edge that ends the first slot.
- R2: `bus_req_o` is high whenever at least one refresh is owed or a refresh sequence is in progress, and low otherwise.
- R3: A sequence starts only in a cycle where `bus_gnt_i` is high and a refresh is owed. Its first phase drives `cas_n_o` low with `ras_n_o` still high for ceil(max(tCSR 5 ns, tWSR 10 ns)/period) cycles, which is 1 cycle at 20 ns.
- R4: `we_n_o` is high in every cycle. `bus_own_o` is high from the first cycle of the setup phase to the last cycle of precharge, and low in the first cycle after precharge ends.
- R5: `ras_n_o` and `cas_n_o` stay low together for ceil(max(tRAS 60, tCHR 10, tWHR 15 ns)/period) cycles, which is 3 at 20 ns. Both strobes then stay high for ceil(max(tRP 40, tRC 104 − tRAS 60, tRPC 5 ns)/period) cycles, which is 3 at 20 ns, before the bus is released.
- R6: Each completed sequence removes one owed refresh. With the grant held, owed refreshes run back to back, and the number of RAS falls equals the owed count.
- R7: The owed count is OWED_W bits wide (default 3) and saturates at 2^OWED_W − 1 (7): further expiries while the count is full are dropped.
- R8: `urgent_o` is high exactly when the owed count is at least URGENT_TH (default 4).
- R9: During reset and right after it, `ras_n_o`, `cas_n_o` and `we_n_o` are high and `bus_req_o`, `bus_own_o` and `urgent_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_gnt_i | input | 1 | Memory bus grant from the access controller |
| bus_req_o | output | 1 | Request for the memory bus |
| urgent_o | output | 1 | Owed count has reached the priority threshold |
| bus_own_o | output | 1 | Scheduler is driving the strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low (held high) |

## Verification
The main instance uses the default 20 ns period and RATE_SEL=0. With a 781-cycle slot, many slots fit in one run: holding the grant off for one, two, four and nine slots drives the owed count below the urgent threshold, onto it and past saturation. Each is followed by a burst with the grant held. Two more instances with RATE_SEL=1 and RATE_SEL=2 place their first request at 390 and 1562 cycles, which covers the other two rate choices. At 20 ns every timing rule rounds to a phase of one to three cycles, so the bench can sample the exact strobe shape cycle by cycle.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SETUP = 2'd1,
    SQ_ACT   = 2'd2,
    SQ_PRE   = 2'd3
  } seq_state_t;

  // Nanoseconds per refresh slot for each rate choice.
  function automatic int unsigned slot_ns(input int unsigned sel);
    case (sel)
      1:       return 64_000_000 / 8192;
      2:       return 128_000_000 / 4096;
      default: return 64_000_000 / 4096;
    endcase
  endfunction

  // Slot length in clock cycles, rounded down so the budget is never exceeded.
  function automatic int unsigned slot_cycles(input int unsigned sel,
                                              input int unsigned per_ns);
    return slot_ns(sel) / per_ns;
  endfunction

  // Minimum time converted to whole cycles, rounded up, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned per_ns);
    int unsigned c;
    c = (ns + per_ns - 1) / per_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cbr_slot_timer.sv
module cbr_slot_timer #(
  parameter int unsigned SLOT_CYC = 781
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic expire_o
);
  localparam int unsigned CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (expire_o) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (SLOT_CYC > 1) begin : g_gap
      // R1: two expiries are never adjacent
      a_r1_expiry_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |=> !expire_o);
    end
  endgenerate

endmodule

// File: rtl/cbr_owed_counter.sv
module cbr_owed_counter #(
  parameter int unsigned OWED_W    = 3,
  parameter int unsigned URGENT_TH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_i,
  input  logic              sub_i,
  output logic [OWED_W-1:0] owed_o,
  output logic              owed_nz_o,
  output logic              urgent_o
);
  localparam logic [OWED_W-1:0] FULL = {OWED_W{1'b1}};
  localparam logic [OWED_W-1:0] TH   = OWED_W'(URGENT_TH);

  logic [OWED_W-1:0] owed_q;
  logic              full_w;

  assign full_w    = (owed_q == FULL);
  assign owed_o    = owed_q;
  assign owed_nz_o = (owed_q != '0);
  assign urgent_o  = (owed_q >= TH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owed_q <= '0;
    end else begin
      case ({add_i, sub_i})
        2'b10:   if (!full_w) owed_q <= owed_q + 1'b1;
        2'b01:   owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end

  // R7: a full count is not wrapped by a further expiry
  a_r7_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && !sub_i && full_w) |=> (owed_o == FULL));
  // R6: a completion never arrives with nothing owed
  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_i |-> owed_nz_o);
  // R8: urgency only rises on an expiry
  a_r8_urgent_on_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(urgent_o) |-> $past(add_i));

endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
  import cbr_refresh_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned ACT_CYC   = 3,
  parameter int unsigned PRE_CYC   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic owed_nz_i,
  input  logic gnt_i,
  output logic start_o,
  output logic done_o,
  output logic busy_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int unsigned LONGEST = max3(SETUP_CYC, ACT_CYC, PRE_CYC);
  localparam int unsigned PW      = $clog2(LONGEST + 1);
  localparam logic [PW-1:0] SETUP_END = PW'(SETUP_CYC - 1);
  localparam logic [PW-1:0] ACT_END   = PW'(ACT_CYC - 1);
  localparam logic [PW-1:0] PRE_END   = PW'(PRE_CYC - 1);

  seq_state_t    st_q;
  logic [PW-1:0] ph_q;
  logic          ph_last;

  always_comb begin
    case (st_q)
      SQ_SETUP: ph_last = (ph_q == SETUP_END);
      SQ_ACT:   ph_last = (ph_q == ACT_END);
      SQ_PRE:   ph_last = (ph_q == PRE_END);
      default:  ph_last = 1'b0;
    endcase
  end

  assign start_o = (st_q == SQ_IDLE) && owed_nz_i && gnt_i;
  assign done_o  = (st_q == SQ_PRE) && ph_last;
  assign busy_o  = (st_q != SQ_IDLE);
  assign ras_n_o = (st_q != SQ_ACT);
  assign cas_n_o = !((st_q == SQ_SETUP) || (st_q == SQ_ACT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SQ_IDLE;
      ph_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          ph_q <= '0;
          if (start_o) st_q <= SQ_SETUP;
        end
        SQ_SETUP, SQ_ACT, SQ_PRE: begin
          if (ph_last) begin
            ph_q <= '0;
            st_q <= (st_q == SQ_SETUP) ? SQ_ACT :
                    (st_q == SQ_ACT)   ? SQ_PRE : SQ_IDLE;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // Run lengths of the row strobe, saturating, for the width checks.
  logic [7:0] low_run_q, high_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run_q  <= '0;
      high_run_q <= '0;
    end else if (!ras_n_o) begin
      high_run_q <= '0;
      if (low_run_q != 8'hFF) low_run_q <= low_run_q + 1'b1;
    end else begin
      low_run_q <= '0;
      if (high_run_q != 8'hFF) high_run_q <= high_run_q + 1'b1;
    end
  end

  // R3: a sequence begins only with the grant held
  a_r3_start_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> gnt_i);
  // R3: column strobe is already low, and was low a cycle before, when row strobe falls
  a_r3_cas_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));
  // R5: row strobe low for at least the active phase
  a_r5_ras_low_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (low_run_q >= 8'(ACT_CYC)));
  // R5: row strobe high for at least the precharge phase before falling again
  a_r5_ras_high_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (high_run_q >= 8'(PRE_CYC + SETUP_CYC)));

endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
  import cbr_refresh_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned RATE_SEL      = 0,
  parameter int unsigned OWED_W        = 3,
  parameter int unsigned URGENT_TH     = 4,
  parameter int unsigned T_CSR_NS      = 5,
  parameter int unsigned T_CHR_NS      = 10,
  parameter int unsigned T_WSR_NS      = 10,
  parameter int unsigned T_WHR_NS      = 15,
  parameter int unsigned T_RPC_NS      = 5,
  parameter int unsigned T_RAS_NS      = 60,
  parameter int unsigned T_RP_NS       = 40,
  parameter int unsigned T_RC_NS       = 104
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_gnt_i,
  output logic bus_req_o,
  output logic urgent_o,
  output logic bus_own_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);
  localparam int unsigned SLOT_CYC  = slot_cycles(RATE_SEL, CLK_PERIOD_NS);
  localparam int unsigned SETUP_CYC = ns_to_cyc(max3(T_CSR_NS, T_WSR_NS, 0), CLK_PERIOD_NS);
  localparam int unsigned ACT_CYC   = ns_to_cyc(max3(T_RAS_NS, T_CHR_NS, T_WHR_NS), CLK_PERIOD_NS);
  localparam int unsigned RC_REST   = (T_RC_NS > T_RAS_NS) ? (T_RC_NS - T_RAS_NS) : 0;
  localparam int unsigned PRE_CYC   = ns_to_cyc(max3(T_RP_NS, RC_REST, T_RPC_NS), CLK_PERIOD_NS);

  logic              slot_expire;
  logic              seq_start, seq_done, seq_busy;
  logic              owed_nz;
  logic [OWED_W-1:0] owed_cnt;

  cbr_slot_timer #(
    .SLOT_CYC (SLOT_CYC)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_o (slot_expire)
  );

  cbr_owed_counter #(
    .OWED_W    (OWED_W),
    .URGENT_TH (URGENT_TH)
  ) u_owed (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .add_i     (slot_expire),
    .sub_i     (seq_done),
    .owed_o    (owed_cnt),
    .owed_nz_o (owed_nz),
    .urgent_o  (urgent_o)
  );

  cbr_strobe_seq #(
    .SETUP_CYC (SETUP_CYC),
    .ACT_CYC   (ACT_CYC),
    .PRE_CYC   (PRE_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .owed_nz_i (owed_nz),
    .gnt_i     (bus_gnt_i),
    .start_o   (seq_start),
    .done_o    (seq_done),
    .busy_o    (seq_busy),
    .ras_n_o   (ras_n_o),
    .cas_n_o   (cas_n_o)
  );

  assign bus_req_o = owed_nz | seq_busy;
  assign bus_own_o = seq_busy;
  assign we_n_o    = 1'b1;

  // R4: any active strobe is driven only while the bus is held
  a_r4_strobes_owned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !cas_n_o) |-> bus_own_o);
  // R2: the request stays up from the start through the end of a sequence
  a_r2_req_through_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_start |=> bus_req_o);
  // R6: a finished sequence with nothing else owed drops the request
  a_r6_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_done && owed_cnt == OWED_W'(1) && !slot_expire) |=> !bus_req_o);

endmodule

// File: tb/cbr_refresh_sched_tb.sv
`timescale 1ns/1ps
module cbr_refresh_sched_tb_top;

  localparam int SLOT0 = 781;
  localparam int SLOT1 = 390;
  localparam int SLOT2 = 1562;
  localparam int NVEC  = 4;

  // Each entry: {slots withheld, expected owed, expected urgent}
  localparam int VEC [NVEC][3] = '{
    '{1, 1, 0},
    '{2, 2, 0},
    '{4, 4, 1},
    '{9, 7, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0;
  logic req, urg, own, ras_n, cas_n, we_n;
  logic req1, urg1, own1, ras1, cas1, we1;
  logic req2, urg2, own2, ras2, cas2, we2;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int rise1 = -1;
  int rise2 = -1;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cbr_refresh_sched dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_gnt_i(gnt), .bus_req_o(req),
    .urgent_o(urg), .bus_own_o(own), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n));

  cbr_refresh_sched #(.RATE_SEL(1)) dut_fast_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_gnt_i(1'b0), .bus_req_o(req1),
    .urgent_o(urg1), .bus_own_o(own1), .ras_n_o(ras1), .cas_n_o(cas1), .we_n_o(we1));

  cbr_refresh_sched #(.RATE_SEL(2)) dut_slow_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_gnt_i(1'b0), .bus_req_o(req2),
    .urgent_o(urg2), .bus_own_o(own2), .ras_n_o(ras2), .cas_n_o(cas2), .we_n_o(we2));

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n && req1 && rise1 < 0) rise1 = cyc;
    if (rst_n && req2 && rise2 < 0) rise2 = cyc;
  end

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Wait at negedges until k more slot expiries have taken effect.
  task automatic wait_slots(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      while (cyc % SLOT0 != 0) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
    end
  end

  initial begin : main
    int falls, prev, owed_exp;
    bit we_ok;
    // R9: reset values
    repeat (3) @(negedge clk);
    chk("R9 ras_n", ras_n, 1);
    chk("R9 cas_n", cas_n, 1);
    chk("R9 we_n", we_n, 1);
    chk("R9 req", req, 0);
    chk("R9 own", own, 0);
    chk("R9 urgent", urg, 0);
    rst_n = 1'b1;

    // R1: first request exactly at the end of the first slot
    while (cyc != SLOT0 - 1) @(negedge clk);
    chk("R1 req before slot end", req, 0);
    chk("R9 own idle after reset", own, 0);
    @(negedge clk);
    chk("R1 req at slot end", req, 1);

    // R3/R4/R5: strobe shape of one refresh, grant given now
    gnt = 1'b1;
    we_ok = 1'b1;
    for (int s = 1; s <= 8; s++) begin
      @(negedge clk);
      if (!we_n) we_ok = 1'b0;
      if (s == 1) begin
        chk("R3 setup cas_n low", cas_n, 0);
        chk("R3 setup ras_n high", ras_n, 1);
        chk("R4 own in setup", own, 1);
      end else if (s <= 4) begin
        chk("R5 active ras_n low", ras_n, 0);
        chk("R5 active cas_n low", cas_n, 0);
      end else if (s <= 7) begin
        chk("R5 precharge ras_n high", ras_n, 1);
        chk("R5 precharge cas_n high", cas_n, 1);
        chk("R4 own in precharge", own, 1);
        chk("R2 req during sequence", req, 1);
      end else begin
        chk("R4 own released", own, 0);
        chk("R6 req cleared", req, 0);
      end
    end
    chk("R4 we_n high throughout", int'(we_ok), 1);
    gnt = 1'b0;

    // R6/R7/R8: withhold grant for several slots, then drain
    for (int v = 0; v < NVEC; v++) begin
      wait_slots(VEC[v][0]);
      repeat (2) @(negedge clk);
      chk($sformatf("R8 urgent after %0d slots", VEC[v][0]), urg, VEC[v][2]);
      chk($sformatf("R2 req pending %0d", VEC[v][0]), req, 1);
      owed_exp = VEC[v][1];
      gnt = 1'b1;
      falls = 0;
      prev = ras_n;
      we_ok = 1'b1;
      for (int c = 0; c < 100; c++) begin
        @(negedge clk);
        if (prev == 1 && ras_n == 0) falls++;
        if (!we_n) we_ok = 1'b0;
        prev = ras_n;
      end
      if (VEC[v][0] > 7)
        chk($sformatf("R7 saturated burst of %0d", VEC[v][0]), falls, owed_exp);
      else
        chk($sformatf("R6 burst of %0d", VEC[v][0]), falls, owed_exp);
      chk("R6 req low after drain", req, 0);
      chk("R8 urgent low after drain", urg, 0);
      chk("R4 we_n high in burst", int'(we_ok), 1);
      gnt = 1'b0;
    end

    // R1: other rate choices
    while (cyc < SLOT2 + 2) @(negedge clk);
    chk("R1 rate 8192/64ms first request", rise1, SLOT1);
    chk("R1 rate 4096/128ms first request", rise2, SLOT2);

    done = 1'b1;
    summary();
  end

endmodule